// File: doc/BRIEF.md
# Inter-processor software interrupt tracker

This block raises and tracks software interrupts sent from one processor to others in a cluster of up to eight processors. A processor starts a broadcast by writing a 32-bit trigger word. The word names one of sixteen interrupt numbers and says how to choose the destinations. The block keeps a pending matrix and an active matrix for each interrupt number. Each matrix holds one bit for every pair of source processor and destination processor.

An interrupt controller upstream picks which interrupt number a processor takes. When a processor acknowledges that number, the block returns, in the same cycle, the lowest-numbered source that has that interrupt pending for it. One cycle later, the bit for that source and destination moves from pending to active. An end-of-interrupt word names the interrupt number and the source, and it retires the matching active bit. A per-destination vector tells the arbiter which processors have any interrupt waiting. A sticky error flag records an acknowledge that finds nothing pending, or an end-of-interrupt for a bit that is not active.

Top module: `sgi_ipi_tracker`

## Requirements
- R1: After reset, no destination shows a waiting interrupt and the error flag is 0.
- R2: The trigger word holds the interrupt number in bits 3:0, the list type in bits 25:24 and an explicit destination list in bits 23:16. List type 0 or 3 sends to the CPUs set in that list. The sending CPU is the source, and the pending bits are visible on the edge after the strobe.
- R3: List type 1 sends to every CPU whose interface is enabled, and the explicit list is ignored.
- R4: List type 2 sends only to the CPU that wrote the trigger.
- R5: A destination whose interface is disabled gets no pending bit.
- R6: An acknowledge reports, in the same cycle, found=1 and the lowest source CPU whose pending bit for the acknowledging CPU is set. On the next edge that bit leaves pending and becomes active.
- R7: An acknowledge that finds no pending bit reports found=0 and sets the error flag.
- R8: In the end-of-interrupt word, bits 9:0 give the interrupt number and bits 12:10 give the source. The word clears the active bit at (destination + 8*source). Retiring a bit that is not active sets the error flag.
- R9: An end-of-interrupt whose number is 16 or more has no effect and raises no error.
- R10: The error flag stays set until reset.
- R11: Waiting bit d is high exactly when some interrupt number has a pending bit in the mask 0x0101010101010101 shifted left by d.
- R12: If a trigger and an acknowledge hit the same pending bit in the same cycle, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| cpu_en | input | 8 | Per-CPU interface enable |
| trig_valid | input | 1 | Trigger write strobe |
| trig_src | input | 3 | CPU writing the trigger |
| trig_word | input | 32 | Trigger word |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | 3 | Acknowledging CPU |
| ack_sgi | input | 4 | Interrupt number being acknowledged |
| ack_found | output | 1 | A pending source was found |
| ack_src | output | 3 | Source CPU reported to the acknowledger |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_cpu | input | 3 | CPU finishing the interrupt |
| eoi_word | input | 32 | End-of-interrupt word |
| sgi_wait | output | 8 | Per-destination "interrupt waiting" vector |
| err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with its default eight CPUs and sixteen interrupt numbers, so the whole 64-bit pair matrix of every number is in use. With this build, a random stream of triggers, acknowledges and end-of-interrupts can drive every source/destination byte. Directed cases cover lowest-source selection, disabled interfaces, same-cycle set against clear, and an out-of-range end-of-interrupt number.

// File: rtl/sgi_ipi_pkg.sv
package sgi_ipi_pkg;
  // trigger word field positions
  localparam int TW_SGI_LO  = 0;
  localparam int TW_LIST_LO = 16;
  localparam int TW_TYPE_LO = 24;
  // end-of-interrupt word field positions
  localparam int EW_ID_LO   = 0;
  localparam int EW_ID_W    = 10;
  localparam int EW_SRC_LO  = 10;

  typedef enum logic [1:0] {
    TL_LIST  = 2'd0,
    TL_ALL   = 2'd1,
    TL_SELF  = 2'd2,
    TL_LIST3 = 2'd3
  } tlist_e;

  // one bit per source group, at the destination position
  function automatic logic [63:0] dest_mask(int ncpu, int d);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < ncpu; k++) r[k*ncpu + d] = 1'b1;
    return r;
  endfunction

  // union of dest_mask over every enabled destination
  function automatic logic [63:0] en_mask(int ncpu, logic [7:0] en);
    logic [63:0] r;
    r = '0;
    for (int d = 0; d < ncpu; d++) if (en[d]) r = r | dest_mask(ncpu, d);
    return r;
  endfunction
endpackage

// File: rtl/sgi_trig_decode.sv
module sgi_trig_decode
  import sgi_ipi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int NSGI = 16,
  localparam int CPU_W = $clog2(NCPU),
  localparam int SGI_W = $clog2(NSGI),
  localparam int MAT_W = NCPU * NCPU
) (
  input  logic             valid,
  input  logic [CPU_W-1:0] src,
  input  logic [31:0]      word,
  input  logic [NCPU-1:0]  cpu_en,
  output logic [SGI_W-1:0] sgi,
  output logic [MAT_W-1:0] set_vec
);
  tlist_e          ltype;
  logic [NCPU-1:0] targets;
  logic [NCPU-1:0] dests;
  logic            unused_word;

  assign unused_word = ^word;
  assign sgi   = word[TW_SGI_LO +: SGI_W];
  assign ltype = tlist_e'(word[TW_TYPE_LO +: 2]);

  always_comb begin
    case (ltype)
      TL_ALL:  targets = cpu_en;
      TL_SELF: targets = NCPU'(1) << src;
      default: targets = word[TW_LIST_LO +: NCPU];
    endcase
    dests   = targets & cpu_en;
    set_vec = valid ? (MAT_W'(dests) << (int'(src) * NCPU)) : '0;
  end
endmodule

// File: rtl/sgi_src_pick.sv
module sgi_src_pick #(
  parameter int NCPU = 8,
  localparam int CPU_W = $clog2(NCPU),
  localparam int MAT_W = NCPU * NCPU
) (
  input  logic [MAT_W-1:0] row,
  input  logic [CPU_W-1:0] dst,
  output logic             found,
  output logic [CPU_W-1:0] src
);
  always_comb begin
    found = 1'b0;
    src   = '0;
    for (int k = NCPU - 1; k >= 0; k--) begin
      if (row[k*NCPU + int'(dst)]) begin
        found = 1'b1;
        src   = CPU_W'(k);
      end
    end
  end
endmodule

// File: rtl/sgi_pair_bank.sv
module sgi_pair_bank #(
  parameter int NCPU = 8,
  parameter int NSGI = 16,
  localparam int SGI_W = $clog2(NSGI),
  localparam int MAT_W = NCPU * NCPU
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SGI_W-1:0] set_sgi,
  input  logic [MAT_W-1:0] set_vec,
  input  logic [SGI_W-1:0] ack_sgi,
  input  logic [MAT_W-1:0] ack_vec,
  input  logic [SGI_W-1:0] eoi_sgi,
  input  logic [MAT_W-1:0] eoi_vec,
  output logic [MAT_W-1:0] pend [NSGI],
  output logic [MAT_W-1:0] act  [NSGI]
);
  for (genvar s = 0; s < NSGI; s++) begin : g_row
    logic [MAT_W-1:0] set_here, ack_here, eoi_here;
    assign set_here = (set_sgi == SGI_W'(s)) ? set_vec : '0;
    assign ack_here = (ack_sgi == SGI_W'(s)) ? ack_vec : '0;
    assign eoi_here = (eoi_sgi == SGI_W'(s)) ? eoi_vec : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend[s] <= '0;
        act[s]  <= '0;
      end else begin
        pend[s] <= (pend[s] & ~ack_here) | set_here;
        act[s]  <= (act[s] & ~eoi_here) | ack_here;
      end
    end
  end
endmodule

// File: rtl/sgi_ipi_tracker.sv
module sgi_ipi_tracker
  import sgi_ipi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int NSGI = 16,
  localparam int CPU_W = $clog2(NCPU),
  localparam int SGI_W = $clog2(NSGI),
  localparam int MAT_W = NCPU * NCPU
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCPU-1:0]  cpu_en,
  input  logic             trig_valid,
  input  logic [CPU_W-1:0] trig_src,
  input  logic [31:0]      trig_word,
  input  logic             ack_valid,
  input  logic [CPU_W-1:0] ack_cpu,
  input  logic [SGI_W-1:0] ack_sgi,
  output logic             ack_found,
  output logic [CPU_W-1:0] ack_src,
  input  logic             eoi_valid,
  input  logic [CPU_W-1:0] eoi_cpu,
  input  logic [31:0]      eoi_word,
  output logic [NCPU-1:0]  sgi_wait,
  output logic             err
);
  logic [SGI_W-1:0]   trig_sgi;
  logic [MAT_W-1:0]   trig_set_vec;
  logic [MAT_W-1:0]   pend [NSGI];
  logic [MAT_W-1:0]   act  [NSGI];
  logic [MAT_W-1:0]   ack_move_vec;
  logic               ack_miss;
  logic [EW_ID_W-1:0] eoi_id;
  logic               eoi_in_range;
  logic [SGI_W-1:0]   eoi_sgi;
  logic [CPU_W-1:0]   eoi_src;
  logic [MAT_W-1:0]   eoi_bit;
  logic [MAT_W-1:0]   eoi_clr_vec;
  logic               eoi_bad;
  logic [MAT_W-1:0]   any_pend;
  logic               err_q;
  logic               unused_eoi;

  sgi_trig_decode #(.NCPU(NCPU), .NSGI(NSGI)) u_dec (
    .valid(trig_valid), .src(trig_src), .word(trig_word),
    .cpu_en(cpu_en), .sgi(trig_sgi), .set_vec(trig_set_vec)
  );

  sgi_src_pick #(.NCPU(NCPU)) u_pick (
    .row(pend[ack_sgi]), .dst(ack_cpu), .found(ack_found), .src(ack_src)
  );

  assign ack_move_vec = (ack_valid && ack_found)
                        ? (MAT_W'(1) << (int'(ack_src) * NCPU + int'(ack_cpu))) : '0;
  assign ack_miss     = ack_valid && !ack_found;

  assign unused_eoi   = ^eoi_word;
  assign eoi_id       = eoi_word[EW_ID_LO +: EW_ID_W];
  assign eoi_in_range = (int'(eoi_id) < NSGI);
  assign eoi_sgi      = eoi_id[SGI_W-1:0];
  assign eoi_src      = eoi_word[EW_SRC_LO +: CPU_W];
  assign eoi_bit      = MAT_W'(1) << (int'(eoi_src) * NCPU + int'(eoi_cpu));
  assign eoi_clr_vec  = (eoi_valid && eoi_in_range) ? eoi_bit : '0;
  assign eoi_bad      = eoi_valid && eoi_in_range && ((act[eoi_sgi] & eoi_bit) == '0);

  sgi_pair_bank #(.NCPU(NCPU), .NSGI(NSGI)) u_bank (
    .clk(clk), .rst(rst),
    .set_sgi(trig_sgi), .set_vec(trig_set_vec),
    .ack_sgi(ack_sgi),  .ack_vec(ack_move_vec),
    .eoi_sgi(eoi_sgi),  .eoi_vec(eoi_clr_vec),
    .pend(pend), .act(act)
  );

  always_comb begin
    logic [63:0] m;
    any_pend = '0;
    for (int s = 0; s < NSGI; s++) any_pend = any_pend | pend[s];
    for (int d = 0; d < NCPU; d++) begin
      m = dest_mask(NCPU, d);
      sgi_wait[d] = |(any_pend & m[MAT_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_q | ack_miss | eoi_bad;
  end
  assign err = err_q;
endmodule

// File: rtl/sgi_ipi_chk.sv
module sgi_ipi_chk
  import sgi_ipi_pkg::*;
#(
  parameter int NCPU = 8,
  localparam int CPU_W = $clog2(NCPU),
  localparam int MAT_W = NCPU * NCPU
) (
  input logic             clk,
  input logic             rst,
  input logic [NCPU-1:0]  cpu_en,
  input logic [MAT_W-1:0] trig_set_vec,
  input logic [MAT_W-1:0] ack_move_vec,
  input logic             ack_valid,
  input logic [CPU_W-1:0] ack_cpu,
  input logic             ack_miss,
  input logic             eoi_valid,
  input logic [CPU_W-1:0] eoi_cpu,
  input logic             eoi_bad,
  input logic [NCPU-1:0]  sgi_wait,
  input logic             err
);
  logic [63:0] en_m;
  assign en_m = en_mask(NCPU, 8'(cpu_en));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);
  // R7
  ack_miss_err_chk: assert property (@(posedge clk) disable iff (rst) ack_miss |=> err);
  // R8
  eoi_bad_err_chk: assert property (@(posedge clk) disable iff (rst) eoi_bad |=> err);
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(ack_miss || eoi_bad));
  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(ack_move_vec));
  // R5
  disabled_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_set_vec & ~en_m[MAT_W-1:0]) == '0);
  // R11
  wait_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(sgi_wait) & ~sgi_wait)) |-> $past(ack_valid));
  // R6
  ack_eoi_split_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack_valid && eoi_valid && ack_cpu == eoi_cpu));
endmodule

bind sgi_ipi_tracker sgi_ipi_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst(rst), .cpu_en(cpu_en), .trig_set_vec(trig_set_vec),
  .ack_move_vec(ack_move_vec), .ack_valid(ack_valid), .ack_cpu(ack_cpu),
  .ack_miss(ack_miss), .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu),
  .eoi_bad(eoi_bad), .sgi_wait(sgi_wait), .err(err)
);

// File: tb/sgi_ipi_tracker_test.sv
module sgi_ipi_tracker_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  cpu_en = 8'hFF;
  logic        trig_valid = 0;
  logic [2:0]  trig_src = 0;
  logic [31:0] trig_word = 0;
  logic        ack_valid = 0;
  logic [2:0]  ack_cpu = 0;
  logic [3:0]  ack_sgi = 0;
  logic        ack_found;
  logic [2:0]  ack_src;
  logic        eoi_valid = 0;
  logic [2:0]  eoi_cpu = 0;
  logic [31:0] eoi_word = 0;
  logic [7:0]  sgi_wait;
  logic        err;

  int total = 0, bad = 0;
  logic [63:0] mp [16];
  logic [63:0] ma [16];
  logic        merr;

  always #10 clk = ~clk;

  sgi_ipi_tracker uut (.*);

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] tw(logic [1:0] ty, logic [7:0] lst, logic [3:0] s);
    return {6'b0, ty, lst, 12'b0, s};
  endfunction
  function automatic logic [31:0] ew(logic [2:0] src, logic [9:0] id);
    return {19'b0, src, id};
  endfunction

  // destinations per the list-type rules, then drop disabled interfaces
  function automatic logic [7:0] model_dests(logic [31:0] w, logic [2:0] src, logic [7:0] en);
    logic [7:0] t;
    if (w[25:24] == 2'd1) t = en;
    else if (w[25:24] == 2'd2) begin t = 0; t[src] = 1; end
    else t = w[23:16];
    return t & en;
  endfunction

  function automatic logic [7:0] model_wait();
    logic [7:0] r = 0;
    for (int s = 0; s < 16; s++)
      for (int k = 0; k < 8; k++)
        for (int d = 0; d < 8; d++)
          if (mp[s][8*k+d]) r[d] = 1;
    return r;
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 16; s++) begin mp[s] = 0; ma[s] = 0; end
    merr = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  // inputs are set after a negedge; this finishes the cycle
  task automatic step(string req);
    logic [63:0] np [16];
    logic [63:0] na [16];
    logic f; logic [2:0] es;
    logic [7:0] ds;
    #2;
    for (int s = 0; s < 16; s++) begin np[s] = mp[s]; na[s] = ma[s]; end
    if (ack_valid) begin
      f = 0; es = 0;
      for (int k = 7; k >= 0; k--) if (mp[ack_sgi][8*k+ack_cpu]) begin f = 1; es = 3'(k); end
      check({req, " R6/R7 found"}, 64'(ack_found), 64'(f));
      if (f) begin
        check({req, " R6 src"}, 64'(ack_src), 64'(es));
        np[ack_sgi][8*es+ack_cpu] = 0;
        na[ack_sgi][8*es+ack_cpu] = 1;
      end else merr = 1;
    end
    if (eoi_valid && eoi_word[9:0] < 16) begin
      if (!ma[eoi_word[3:0]][8*eoi_word[12:10]+eoi_cpu]) merr = 1;
      else na[eoi_word[3:0]][8*eoi_word[12:10]+eoi_cpu] = 0;
    end
    if (trig_valid) begin
      ds = model_dests(trig_word, trig_src, cpu_en);
      for (int d = 0; d < 8; d++) if (ds[d]) np[trig_word[3:0]][8*trig_src+d] = 1;
    end
    @(posedge clk);
    for (int s = 0; s < 16; s++) begin mp[s] = np[s]; ma[s] = na[s]; end
    @(negedge clk);
    trig_valid = 0; ack_valid = 0; eoi_valid = 0;
    check({req, " R11 wait"}, 64'(sgi_wait), 64'(model_wait()));
    check({req, " R10 err"}, 64'(err), 64'(merr));
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    model_clear();
    @(negedge clk);
    do_reset();
    check("R1 wait", 64'(sgi_wait), 0);
    check("R1 err", 64'(err), 0);

    // R2 explicit list
    trig_valid = 1; trig_src = 3; trig_word = tw(2'd0, 8'h05, 4'd7); step("R2");
    check("R2 wait05", 64'(sgi_wait), 64'h05);
    // R4 self only, list ignored
    trig_valid = 1; trig_src = 1; trig_word = tw(2'd2, 8'hFF, 4'd7); step("R4");
    check("R4 wait07", 64'(sgi_wait), 64'h07);
    // R3 and R5: broadcast with CPU3 disabled
    cpu_en = 8'hF7;
    trig_valid = 1; trig_src = 5; trig_word = tw(2'd1, 8'h00, 4'd2); step("R3");
    check("R3/R5 waitF7", 64'(sgi_wait), 64'hF7);
    // R5 explicit list naming only a disabled CPU
    trig_valid = 1; trig_src = 0; trig_word = tw(2'd3, 8'h08, 4'd9); step("R5");
    check("R5 wait no cpu3", 64'(sgi_wait[3]), 0);
    cpu_en = 8'hFF;
    // R6 lowest source
    trig_valid = 1; trig_src = 6; trig_word = tw(2'd0, 8'h01, 4'd7); step("R6 setup");
    ack_valid = 1; ack_cpu = 0; ack_sgi = 7; #1;
    check("R6 first src", 64'(ack_src), 3);
    step("R6 a");
    ack_valid = 1; ack_cpu = 0; ack_sgi = 7; #1;
    check("R6 second src", 64'(ack_src), 6);
    step("R6 b");
    // R9 out-of-range id
    eoi_valid = 1; eoi_cpu = 0; eoi_word = ew(3'd3, 10'd20); step("R9");
    check("R9 err", 64'(err), 0);
    // R8 retire then retire again
    eoi_valid = 1; eoi_cpu = 0; eoi_word = ew(3'd3, 10'd7); step("R8 ok");
    check("R8 no err", 64'(err), 0);
    eoi_valid = 1; eoi_cpu = 0; eoi_word = ew(3'd3, 10'd7); step("R8 dup");
    check("R8 err", 64'(err), 1);
    repeat (3) begin step("R10 hold"); check("R10 sticky", 64'(err), 1); end
    do_reset();
    check("R1 after reset err", 64'(err), 0);
    // R7 acknowledge with nothing pending
    ack_valid = 1; ack_cpu = 4; ack_sgi = 9; #1;
    check("R7 found0", 64'(ack_found), 0);
    step("R7");
    check("R7 err", 64'(err), 1);
    do_reset();
    // R12 same-cycle trigger and acknowledge on one bit
    trig_valid = 1; trig_src = 2; trig_word = tw(2'd0, 8'h10, 4'd4); step("R12 setup");
    trig_valid = 1; trig_src = 2; trig_word = tw(2'd0, 8'h10, 4'd4);
    ack_valid = 1; ack_cpu = 4; ack_sgi = 4; step("R12 both");
    check("R12 still waiting", 64'(sgi_wait[4]), 1);
    ack_valid = 1; ack_cpu = 4; ack_sgi = 4; #1;
    check("R12 found again", 64'(ack_found), 1);
    step("R12 ack");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      if (n == 2000) do_reset();
      cpu_en = ($urandom % 8 == 0) ? 8'($urandom) : 8'hFF;
      if ($urandom % 3 == 0) begin
        trig_valid = 1; trig_src = 3'($urandom);
        trig_word = tw(2'($urandom), 8'($urandom), 4'($urandom));
      end
      if ($urandom % 2 == 0) begin
        ack_cpu = 3'($urandom);
        ack_sgi = 4'($urandom);
        for (int i = 0; i < 16; i++) begin
          logic [3:0] s;
          s = 4'(int'(ack_sgi) + i);
          if ((mp[s] & (64'h0101010101010101 << ack_cpu)) != 0) begin
            ack_sgi = s; ack_valid = 1; break;
          end
        end
        if (!ack_valid && $urandom % 50 == 0) ack_valid = 1;
      end
      if ($urandom % 2 == 0) begin
        int st;
        st = $urandom % 1024;
        for (int i = 0; i < 1024; i++) begin
          int p, s, b;
          p = (st + i) % 1024; s = p / 64; b = p % 64;
          if (ma[s][b] && !(ack_valid && 3'(b % 8) == ack_cpu)) begin
            eoi_valid = 1; eoi_cpu = 3'(b % 8); eoi_word = ew(3'(b / 8), 10'(s));
            break;
          end
        end
        if (!eoi_valid && $urandom % 40 == 0) begin
          eoi_valid = 1; eoi_cpu = ack_cpu + 3'd1;
          eoi_word = ew(3'($urandom), 10'($urandom % 24));
        end
      end
      step("RND R2-R12");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule